// File: doc/BRIEF.md
# Debug power and reset control register

This block is a small control register that a debugger uses to steer processor power and reset. Three access paths reach it through one shared access port: a memory-mapped debug bus, an external debug port and an internal system-register path. A two-bit selector says which path the current access comes from. Each path gets its own view of the register.

The register drives four outputs:
- a power-up request to the power controller;
- a no-power-down request, which asks the power controller to emulate power-down and keep the core alive;
- a single-cycle warm-reset request to the reset generator;
- a hold signal that keeps the non-debug logic in reset after a power-up or warm-reset event.

Three status inputs gate the accesses: core-powered, double lock and OS lock. The two request bits that live in the debug power domain survive a core power-down. The no-power-down bit lives in the core domain and is lost when the core powers down.

Top module: `dbg_pwr_rst_ctl`

## Requirements
- R1: After reset, every output is 0. A read from any path returns 0.
- R2: Bits [31:4] read as 0 and ignore writes. Bit 1 always reads as 0.
- R3: Path encodings are 00 for memory-mapped, 01 for external, 10 for internal system-register and 11 for unused.
  - Bit 3 drives `pwrup_req`.
  - Bit 3 can be written from paths 00 and 01.
  - Path 11 changes nothing, and reads through path 11 return 0.
- R4: Through path 10, bits 3 and 2 read as 0, and writes to them are ignored. This includes attempts to clear the hold enable.
- R5: A write of 1 to bit 1 that is accepted produces `warm_rst_req` for exactly one cycle, in the cycle after the write. A write of 0 to bit 1 produces nothing.
- R6: A write to bits 1 and 0 is ignored in any of these cases:
  - `core_pwr_on` is 0;
  - `dbl_lock` is 1;
  - the write comes from path 01 while `os_lock` is 1.
  OS lock does not block paths 00 and 10.
- R7: Bit 0 drives `no_pwrdn_req` directly. Bit 0 clears to 0 in the cycle after `core_pwr_on` is seen low.
- R8: While `core_pwr_on` is 0 or `dbl_lock` is 1, bit 0 reads as 0. The stored value is not changed by this.
- R9: `hold_rst` rises in the cycle after `pwrup_evt` or `warm_rst_evt` while bit 2 is 1. An event while bit 2 is 0 leaves `hold_rst` at 0.
- R10: `hold_rst` falls in the cycle after a write of 0 to bit 2 is accepted.
- R11: Read data is combinational in the cycle of the read. Read data is all zeros while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| path_sel | input | 2 | Access path of the current access (00 memory-mapped, 01 external, 10 internal, 11 unused) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |
| core_pwr_on | input | 1 | Core power domain is on |
| dbl_lock | input | 1 | Double lock is set |
| os_lock | input | 1 | OS lock is set |
| pwrup_evt | input | 1 | Power-up event pulse |
| warm_rst_evt | input | 1 | Warm-reset event pulse |
| pwrup_req | output | 1 | Power-up request |
| no_pwrdn_req | output | 1 | No-power-down (emulate) request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |
| hold_rst | output | 1 | Hold non-debug logic in reset |

## Verification
The state of bits 3 and 0 appears at once on `pwrup_req` and `no_pwrdn_req`, so a wrongly stored value shows in the cycle after the write. Errors in the path masks or the lock masks touch only read data. They are seen in the same cycle as a read issued through the affected path under the affected lock. A wrong hold enable stays hidden until the next power-up or warm-reset event. It then shows one cycle later as a missing or stray `hold_rst`.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    PATH_MEM  = 2'b00,
    PATH_EXT  = 2'b01,
    PATH_SYS  = 2'b10,
    PATH_NONE = 2'b11
  } dpr_path_e;

  localparam int BIT_NOPD = 0;
  localparam int BIT_WRST = 1;
  localparam int BIT_HOLD = 2;
  localparam int BIT_PWUP = 3;
  localparam int CTL_W    = 4;

  typedef struct packed {
    logic pwup;
    logic hold;
    logic nopd;
  } dpr_state_t;

  typedef struct packed {
    logic wr_dbg;
    logic wr_core;
    logic rd_dbg;
    logic rd_core;
  } dpr_gate_t;

endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dpr_gate.sv
module dpr_gate
  import dpr_pkg::*;
(
  input  logic [1:0] path_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       core_pwr_on,
  input  logic       dbl_lock,
  input  logic       os_lock,
  output dpr_gate_t  gate
);
  logic dbg_path;
  logic any_path;
  logic core_ok;
  logic os_block;

  always_comb begin
    dbg_path = (path_sel == PATH_MEM) || (path_sel == PATH_EXT);
    any_path = (path_sel != PATH_NONE);
    core_ok  = core_pwr_on && !dbl_lock;
    os_block = (path_sel == PATH_EXT) && os_lock;

    gate.wr_dbg  = wr_en && dbg_path;
    gate.rd_dbg  = rd_en && dbg_path;
    gate.wr_core = wr_en && any_path && core_ok && !os_block;
    gate.rd_core = rd_en && any_path && core_ok;
  end
endmodule

// File: rtl/dpr_regs.sv
module dpr_regs
  import dpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dpr_gate_t        gate,
  input  logic [CTL_W-1:0] wr_bits,
  input  logic             core_pwr_on,
  output dpr_state_t       state,
  output logic             wrst_pulse
);
  dpr_state_t state_q, state_d;
  logic       pulse_q, pulse_d;
  logic       en_dbg, en_core;

  always_comb begin
    en_dbg  = gate.wr_dbg;
    en_core = gate.wr_core || !core_pwr_on;

    state_d = state_q;
    if (gate.wr_dbg) begin
      state_d.pwup = wr_bits[BIT_PWUP];
      state_d.hold = wr_bits[BIT_HOLD];
    end
    if (!core_pwr_on)      state_d.nopd = 1'b0;
    else if (gate.wr_core) state_d.nopd = wr_bits[BIT_NOPD];

    pulse_d = gate.wr_core && wr_bits[BIT_WRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q.pwup <= 1'b0;
      state_q.hold <= 1'b0;
    end else if (en_dbg) begin
      state_q.pwup <= state_d.pwup;
      state_q.hold <= state_d.hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q.nopd <= 1'b0;
    else if (en_core) state_q.nopd <= state_d.nopd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign state      = state_q;
  assign wrst_pulse = pulse_q;
endmodule

// File: rtl/dpr_hold.sv
module dpr_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_en,
  input  logic hold_clr,
  input  logic pwrup_evt,
  input  logic warm_rst_evt,
  output logic hold_rst
);
  logic hold_q, hold_d;
  logic set_req;

  always_comb begin
    set_req = hold_en && (pwrup_evt || warm_rst_evt);
    hold_d  = hold_q;
    if (hold_clr)     hold_d = 1'b0;
    else if (set_req) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold_rst = hold_q;
endmodule

// File: rtl/dbg_pwr_rst_ctl.sv
module dbg_pwr_rst_ctl
  import dpr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        path_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              core_pwr_on,
  input  logic              dbl_lock,
  input  logic              os_lock,
  input  logic              pwrup_evt,
  input  logic              warm_rst_evt,
  output logic              pwrup_req,
  output logic              no_pwrdn_req,
  output logic              warm_rst_req,
  output logic              hold_rst
);
  localparam int RSV_W = DATA_W - CTL_W;

  logic       rst_sync_n;
  dpr_gate_t  gate;
  dpr_state_t state;
  logic       unused_rsv_bits;

  assign unused_rsv_bits = ^wr_data[DATA_W-1:CTL_W];

  dpr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dpr_gate u_gate (
    .path_sel    (path_sel),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .core_pwr_on (core_pwr_on),
    .dbl_lock    (dbl_lock),
    .os_lock     (os_lock),
    .gate        (gate)
  );

  dpr_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .gate        (gate),
    .wr_bits     (wr_data[CTL_W-1:0]),
    .core_pwr_on (core_pwr_on),
    .state       (state),
    .wrst_pulse  (warm_rst_req)
  );

  dpr_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .hold_en      (state.hold),
    .hold_clr     (gate.wr_dbg && !wr_data[BIT_HOLD]),
    .pwrup_evt    (pwrup_evt),
    .warm_rst_evt (warm_rst_evt),
    .hold_rst     (hold_rst)
  );

  always_comb begin
    rd_data = {{RSV_W{1'b0}},
               state.pwup && gate.rd_dbg,
               state.hold && gate.rd_dbg,
               1'b0,
               state.nopd && gate.rd_core};
  end

  assign pwrup_req    = state.pwup;
  assign no_pwrdn_req = state.nopd;
endmodule

// File: rtl/dpr_ctl_chk.sv
module dpr_ctl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        path_sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              core_pwr_on,
  input logic              dbl_lock,
  input logic              os_lock,
  input logic              pwrup_evt,
  input logic              warm_rst_evt,
  input logic              no_pwrdn_req,
  input logic              warm_rst_req,
  input logic              hold_rst
);

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DATA_W-1:4] == '0) && !rd_data[1]);

  p_sys_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && path_sel == 2'b10) |-> (rd_data[3:2] == 2'b00));

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |-> ($past(wr_en) && $past(wr_data[1]) && $past(core_pwr_on)
                      && !$past(dbl_lock) && ($past(path_sel) != 2'b11)));

  p_ext_os_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && path_sel == 2'b01 && os_lock) |=> !warm_rst_req);

  p_nopd_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_on && (dbl_lock || !wr_en)) |=> $stable(no_pwrdn_req));

  p_core_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_on |=> !no_pwrdn_req);

  p_locked_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_pwr_on || dbl_lock) |-> !rd_data[0]);

  p_hold_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_rst) |-> $past(pwrup_evt || warm_rst_evt));

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

bind dbg_pwr_rst_ctl dpr_ctl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dbg_pwr_rst_ctl_bench.sv
module dbg_pwr_rst_ctl_bench;
  localparam logic [1:0] P_MEM = 2'b00;
  localparam logic [1:0] P_EXT = 2'b01;
  localparam logic [1:0] P_SYS = 2'b10;
  localparam logic [1:0] P_NON = 2'b11;
  localparam int S_RD = 0, S_PWUP = 1, S_NOPD = 2, S_WRST = 3, S_HOLD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  path_sel;
  logic        wr_en, rd_en;
  logic [31:0] wr_data, rd_data;
  logic        core_pwr_on, dbl_lock, os_lock, pwrup_evt, warm_rst_evt;
  logic        pwrup_req, no_pwrdn_req, warm_rst_req, hold_rst;

  always #2 clk = ~clk;

  dbg_pwr_rst_ctl u_dbg_pwr_rst_ctl (
    .clk(clk), .rst_n(rst_n), .path_sel(path_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .core_pwr_on(core_pwr_on), .dbl_lock(dbl_lock), .os_lock(os_lock),
    .pwrup_evt(pwrup_evt), .warm_rst_evt(warm_rst_evt),
    .pwrup_req(pwrup_req), .no_pwrdn_req(no_pwrdn_req),
    .warm_rst_req(warm_rst_req), .hold_rst(hold_rst)
  );

  typedef struct {
    int          due;
    int          sig;
    logic [31:0] val;
    string       req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int base = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void exp_at(int d, int s, logic [31:0] v, string r);
    item_t it;
    int i;
    it.due = base + d; it.sig = s; it.val = v; it.req = r;
    i = sb.size();
    while (i > 0 && sb[i-1].due > it.due) i--;
    sb.insert(i, it);
  endfunction

  function automatic logic [31:0] actual(int s);
    case (s)
      S_RD:    return rd_data;
      S_PWUP:  return {31'd0, pwrup_req};
      S_NOPD:  return {31'd0, no_pwrdn_req};
      S_WRST:  return {31'd0, warm_rst_req};
      default: return {31'd0, hold_rst};
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [31:0] a;
        it = sb.pop_front();
        a = actual(it.sig);
        checks++;
        if (a !== it.val) begin
          errors++;
          $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h",
                   it.req, it.sig, cyc, a, it.val);
        end
      end
    end
  end

  task automatic drive(input logic we, input logic re, input logic [1:0] ps,
                       input logic [31:0] d, input logic pe, input logic wev);
    @(negedge clk);
    base = cyc;
    wr_en = we; rd_en = re; path_sel = ps; wr_data = d;
    pwrup_evt = pe; warm_rst_evt = wev;
  endtask

  task automatic set_st(input logic core, input logic dl, input logic os);
    @(negedge clk);
    base = cyc;
    core_pwr_on = core; dbl_lock = dl; os_lock = os;
    wr_en = 0; rd_en = 0; path_sel = P_MEM; wr_data = 0;
    pwrup_evt = 0; warm_rst_evt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; path_sel = P_MEM; wr_en = 0; rd_en = 0; wr_data = 0;
    core_pwr_on = 1; dbl_lock = 0; os_lock = 0; pwrup_evt = 0; warm_rst_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    drive(0, 1, P_MEM, 0, 0, 0);
    exp_at(0, S_RD, 0, "R1"); exp_at(0, S_PWUP, 0, "R1"); exp_at(0, S_NOPD, 0, "R1");
    exp_at(0, S_WRST, 0, "R1"); exp_at(0, S_HOLD, 0, "R1");

    // full write: b3=1 b2=1 b0=1, warm pulse
    drive(1, 0, P_MEM, 32'hFFFF_FFFF, 0, 0);
    exp_at(1, S_PWUP, 1, "R3"); exp_at(1, S_NOPD, 1, "R7");
    exp_at(1, S_WRST, 1, "R5"); exp_at(2, S_WRST, 0, "R5");
    exp_at(1, S_HOLD, 0, "R9");
    drive(0, 0, P_MEM, 0, 0, 0);
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'hD, "R2");
    drive(0, 1, P_SYS, 0, 0, 0); exp_at(0, S_RD, 32'h1, "R4");

    // internal write 0: b0 clears, b3/b2 kept, no pulse
    drive(1, 0, P_SYS, 0, 0, 0);
    exp_at(1, S_NOPD, 0, "R7"); exp_at(1, S_PWUP, 1, "R4"); exp_at(1, S_WRST, 0, "R5");
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'hC, "R4");
    drive(1, 0, P_SYS, 32'h2, 0, 0); exp_at(1, S_WRST, 1, "R5");

    // OS lock blocks external path only
    set_st(1, 0, 1);
    drive(1, 0, P_EXT, 32'hF, 0, 0);
    exp_at(1, S_WRST, 0, "R6"); exp_at(1, S_NOPD, 0, "R6");
    drive(1, 0, P_MEM, 32'hD, 0, 0); exp_at(1, S_NOPD, 1, "R6");

    // double lock
    set_st(1, 1, 0);
    drive(1, 0, P_MEM, 32'hE, 0, 0);
    exp_at(1, S_WRST, 0, "R6"); exp_at(1, S_NOPD, 1, "R6");
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'hC, "R8");
    set_st(1, 0, 0);
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'hD, "R8");

    // core power-down
    set_st(0, 0, 0); exp_at(1, S_NOPD, 0, "R7");
    drive(1, 0, P_MEM, 32'hF, 0, 0);
    exp_at(1, S_WRST, 0, "R6"); exp_at(1, S_NOPD, 0, "R6");
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'hC, "R8");
    set_st(1, 0, 0);
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'hC, "R7");

    // hold-reset: b3=1 b2=1 b0=0
    drive(0, 0, P_MEM, 0, 1, 0); exp_at(1, S_HOLD, 1, "R9");
    drive(0, 0, P_MEM, 0, 0, 0); exp_at(1, S_HOLD, 1, "R9");
    drive(1, 0, P_SYS, 0, 0, 0);
    exp_at(1, S_HOLD, 1, "R4"); exp_at(1, S_PWUP, 1, "R4");
    drive(1, 0, P_EXT, 32'h8, 0, 0); exp_at(1, S_HOLD, 0, "R10");
    drive(0, 0, P_MEM, 0, 1, 0); exp_at(1, S_HOLD, 0, "R9");
    drive(1, 0, P_MEM, 32'h4, 0, 0);
    exp_at(1, S_PWUP, 0, "R3"); exp_at(1, S_HOLD, 0, "R9");
    drive(0, 0, P_MEM, 0, 0, 1); exp_at(1, S_HOLD, 1, "R9");

    // reserved write, clears b3/b2
    drive(1, 0, P_MEM, 32'hFFFF_FFF0, 0, 0); exp_at(1, S_HOLD, 0, "R10");
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 0, "R2");

    // unused path
    drive(1, 0, P_NON, 32'hF, 0, 0);
    exp_at(1, S_PWUP, 0, "R3"); exp_at(1, S_NOPD, 0, "R3"); exp_at(1, S_WRST, 0, "R3");
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 0, "R3");
    drive(1, 0, P_MEM, 32'h9, 0, 0);
    drive(0, 1, P_NON, 0, 0, 0); exp_at(0, S_RD, 0, "R3");
    drive(0, 0, P_MEM, 0, 0, 0); exp_at(0, S_RD, 0, "R11");
    drive(0, 1, P_MEM, 0, 0, 0); exp_at(0, S_RD, 32'h9, "R11");
    drive(0, 0, P_MEM, 0, 0, 0);
    repeat (4) @(negedge clk);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    finish_run();
  end
endmodule